// File: doc/BRIEF.md
# Operating Mode Control Register

This block holds the operating mode of a microcontroller together with a few controls tied to it. While reset is held it samples two strap pins on every clock, and when reset is released it keeps the last sampled values. Those values set the special-mode flag and the mode-select flag. From the straps it also fixes the reset-vector window, sets the reset value of the boot ROM enable, and loads a fixed default into a 4-bit priority-select field.

Software reaches the block through one byte-wide register at a single decoded address. What a write can change depends on the mode the part is in. In the special modes (bootstrap and test), the mode flags, the boot ROM enable and the internal-read-visibility flag can all be written. In the normal modes (single-chip and expanded), the mode flags and the boot ROM enable are frozen, and the visibility flag takes only the first write after reset. Once the special-mode flag is cleared, software cannot set it again. The priority field can be written in every mode. Its value is passed out for an interrupt arbiter that lives elsewhere.

Top module: `opmode_ctl_reg`

## Requirements
- R1: After reset, `mode_code` equals {not `strap_b`, `strap_a`}, using the values of the straps at the last clock of reset. The encoding is 00 single-chip, 01 expanded, 10 bootstrap and 11 test. Bit 1 is the special-mode flag and bit 0 is the mode-select flag.
- R2: The register byte is laid out as: boot ROM enable at bit 7, special flag at bit 6, mode-select flag at bit 5, visibility flag at bit 4, and priority at bits 3:0. After reset the boot ROM enable reads 1 only in bootstrap mode, the visibility flag reads 0, and the priority reads 0110.
- R3: `vec_base` is FFFA hex if `strap_b` was 1 at reset and BFFA hex if it was 0. Register writes never change it.
- R4: `boot_rom_on` always equals the boot ROM enable bit.
- R5: While the special flag is 1, a write loads bits 7, 6, 5 and 4 from the write data. This includes clearing the special flag.
- R6: While the special flag is 0, writes leave bits 7, 6 and 5 unchanged.
- R7: Once the special flag is 0, it stays 0 until the next reset.
- R8: While the special flag is 0, only the first register write after reset may change the visibility flag. Every later write leaves it unchanged.
- R9: `show_reads` is 1 only when the visibility flag is 1 and the mode-select flag is 1 (expanded or test mode). In single-chip and bootstrap modes it is 0.
- R10: Every write loads bits 3:0 into the priority field in any mode, and `prio_sel` shows that field.
- R11: A write strobe with an address other than `REG_ADDR` changes nothing. `reg_rdata` is 0 whenever `reg_addr` is not `REG_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; the straps are sampled while it is low |
| strap_a | input | 1 | Mode strap giving the mode-select flag |
| strap_b | input | 1 | Mode strap; its inverse gives the special flag |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| mode_code | output | 2 | Current mode {special, mode-select} |
| vec_base | output | 16 | Base address of the reset-vector window |
| boot_rom_on | output | 1 | Boot ROM mapped |
| show_reads | output | 1 | Internal reads driven onto the external bus |
| prio_sel | output | 4 | Priority select for the interrupt arbiter |

## Verification
The assertions assume that the straps do not change in the last two clocks before reset is released. Under that assumption the reset-vector window checked after release matches the mode. They also assume that `reg_wr` is a clean single-cycle strobe, so that each write hit stands for exactly one update. The bench sets the straps several cycles before releasing reset and holds them there. It raises the strobe for exactly one clock per write, on the falling edge.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  localparam int PRIO_W = 4;
  localparam logic [PRIO_W-1:0] PRIO_RST = 4'b0110;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXP    = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } opmode_e;

  typedef struct packed {
    logic              rboot;
    logic              smod;
    logic              mda;
    logic              irv;
    logic [PRIO_W-1:0] prio;
  } ctl_fields_t;

  // Reset contents derived from the two strap levels.
  function automatic ctl_fields_t f_reset_fields(input logic pin_a, input logic pin_b);
    ctl_fields_t f;
    f.smod  = ~pin_b;
    f.mda   = pin_a;
    f.rboot = ~pin_b & ~pin_a;
    f.irv   = 1'b0;
    f.prio  = PRIO_RST;
    return f;
  endfunction

  // Visibility only meaningful where an external bus exists.
  function automatic logic f_visible(input logic irv, input logic mda);
    return irv & mda;
  endfunction

  function automatic logic [15:0] f_vec_base(input logic pin_b_rst,
                                             input logic [15:0] vec_norm,
                                             input logic [15:0] vec_spec);
    return pin_b_rst ? vec_norm : vec_spec;
  endfunction

endpackage

// File: rtl/opmode_strap_latch.sv
module opmode_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_b,
  output logic strap_b_q
);
  // Tracks the strap while reset is low, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_b_q <= strap_b;
  end
endmodule

// File: rtl/opmode_wr_perm.sv
module opmode_wr_perm
  import opmode_pkg::*;
(
  input  ctl_fields_t cur,
  input  logic        irv_locked,
  input  logic        wr_hit,
  input  logic [7:0]  wdata,
  output ctl_fields_t nxt,
  output logic        lock_set
);
  ctl_fields_t wf;

  always_comb begin
    wf       = ctl_fields_t'(wdata);
    nxt      = cur;
    lock_set = 1'b0;
    if (wr_hit) begin
      nxt.prio = wf.prio;
      if (cur.smod) begin
        nxt.rboot = wf.rboot;
        nxt.smod  = wf.smod;
        nxt.mda   = wf.mda;
        nxt.irv   = wf.irv;
      end else begin
        lock_set = 1'b1;
        if (!irv_locked) nxt.irv = wf.irv;
      end
    end
  end
endmodule

// File: rtl/opmode_ctl_core.sv
module opmode_ctl_core
  import opmode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_a,
  input  logic        strap_b,
  input  ctl_fields_t nxt,
  input  logic        lock_set,
  output ctl_fields_t cur,
  output logic        irv_locked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur        <= f_reset_fields(strap_a, strap_b);
      irv_locked <= 1'b0;
    end else begin
      cur        <= nxt;
      irv_locked <= irv_locked | lock_set;
    end
  end
endmodule

// File: rtl/opmode_out_decode.sv
module opmode_out_decode
  import opmode_pkg::*;
#(
  parameter logic [15:0] VEC_NORM = 16'hFFFA,
  parameter logic [15:0] VEC_SPEC = 16'hBFFA
) (
  input  ctl_fields_t      cur,
  input  logic             addr_hit,
  input  logic             strap_b_q,
  output logic [7:0]       rdata,
  output logic [1:0]       mode_code,
  output logic [15:0]      vec_base,
  output logic             boot_rom_on,
  output logic             show_reads,
  output logic [PRIO_W-1:0] prio_sel
);
  always_comb begin
    rdata       = addr_hit ? 8'(cur) : 8'h00;
    mode_code   = {cur.smod, cur.mda};
    vec_base    = f_vec_base(strap_b_q, VEC_NORM, VEC_SPEC);
    boot_rom_on = cur.rboot;
    show_reads  = f_visible(cur.irv, cur.mda);
    prio_sel    = cur.prio;
  end
endmodule

// File: rtl/opmode_ctl_reg.sv
module opmode_ctl_reg
  import opmode_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] REG_ADDR = 6'h3C,
  parameter logic [15:0] VEC_NORM = 16'hFFFA,
  parameter logic [15:0] VEC_SPEC = 16'hBFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_a,
  input  logic              strap_b,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [1:0]        mode_code,
  output logic [15:0]       vec_base,
  output logic              boot_rom_on,
  output logic              show_reads,
  output logic [3:0]        prio_sel
);
  logic        addr_hit;
  logic        wr_hit;
  logic        lock_set;
  logic        irv_locked;
  logic        strap_b_q;
  logic        irv_now;
  ctl_fields_t cur;
  ctl_fields_t nxt;

  assign addr_hit = (reg_addr == REG_ADDR);
  assign wr_hit   = reg_wr & addr_hit;
  assign irv_now  = cur.irv;

  opmode_strap_latch u_latch (
    .clk(clk), .rst_n(rst_n), .strap_b(strap_b), .strap_b_q(strap_b_q)
  );

  opmode_wr_perm u_perm (
    .cur(cur), .irv_locked(irv_locked), .wr_hit(wr_hit), .wdata(reg_wdata),
    .nxt(nxt), .lock_set(lock_set)
  );

  opmode_ctl_core u_core (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .nxt(nxt), .lock_set(lock_set), .cur(cur), .irv_locked(irv_locked)
  );

  opmode_out_decode #(.VEC_NORM(VEC_NORM), .VEC_SPEC(VEC_SPEC)) u_dec (
    .cur(cur), .addr_hit(addr_hit), .strap_b_q(strap_b_q),
    .rdata(reg_rdata), .mode_code(mode_code), .vec_base(vec_base),
    .boot_rom_on(boot_rom_on), .show_reads(show_reads), .prio_sel(prio_sel)
  );
endmodule

// File: rtl/opmode_ctl_chk.sv
module opmode_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_hit,
  input logic        irv_locked,
  input logic        irv_now,
  input logic [7:0]  reg_wdata,
  input logic [1:0]  mode_code,
  input logic [15:0] vec_base,
  input logic        boot_rom_on,
  input logic        show_reads,
  input logic [3:0]  prio_sel
);
  AST_SMOD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_code[1] |=> !mode_code[1]); // R7

  AST_NORMAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_code[1] && wr_hit) |=> ($stable(mode_code) && $stable(boot_rom_on))); // R6

  AST_IRV_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_code[1] && irv_locked) |=> $stable(irv_now)); // R8

  AST_VIS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    show_reads |-> (mode_code[0] && irv_now)); // R9

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(vec_base)); // R3

  AST_PRIO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (prio_sel == $past(reg_wdata[3:0]))); // R10
endmodule

bind opmode_ctl_reg opmode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .irv_locked(irv_locked),
  .irv_now(irv_now), .reg_wdata(reg_wdata), .mode_code(mode_code),
  .vec_base(vec_base), .boot_rom_on(boot_rom_on), .show_reads(show_reads),
  .prio_sel(prio_sel)
);

// File: tb/opmode_ctl_reg_tb_top.sv
module opmode_ctl_reg_tb_top;
  localparam logic [5:0] RA = 6'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_a = 1'b0, strap_b = 1'b1;
  logic [5:0] reg_addr = RA;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] mode_code;
  logic [15:0] vec_base;
  logic       boot_rom_on, show_reads;
  logic [3:0] prio_sel;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  opmode_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mode_code(mode_code), .vec_base(vec_base),
    .boot_rom_on(boot_rom_on), .show_reads(show_reads), .prio_sel(prio_sel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic a, input logic b);
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = RA;
    strap_a = a; strap_b = b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = RA;
  endtask

  // Reset state in all four strap combinations.
  task automatic t_reset_modes();
    for (int i = 0; i < 4; i++) begin
      logic a, b, sm;
      a = i[0]; b = i[1]; sm = ~b;
      do_reset(a, b);
      chk("R1 mode", 16'(mode_code), 16'({sm, a}));
      chk("R2 rdata", 16'(reg_rdata), 16'({sm & ~a, sm, a, 1'b0, 4'b0110}));
      chk("R3 vec", vec_base, b ? 16'hFFFA : 16'hBFFA);
      chk("R4 boot", 16'(boot_rom_on), 16'(sm & ~a));
      chk("R9 vis", 16'(show_reads), 16'h0);
      chk("R10 prio", 16'(prio_sel), 16'h6);
    end
  endtask

  // Special-mode writes, then leaving special mode.
  task automatic t_special();
    do_reset(1'b0, 1'b0);
    wr(RA, 8'b0111_1010);
    chk("R5 rdata", 16'(reg_rdata), 16'h7A);
    chk("R5 mode", 16'(mode_code), 16'h3);
    chk("R9 vis test", 16'(show_reads), 16'h1);
    chk("R4 boot off", 16'(boot_rom_on), 16'h0);
    wr(RA, 8'b1001_0101);
    chk("R5 clear smod", 16'(reg_rdata), 16'h95);
    chk("R9 vis single", 16'(show_reads), 16'h0);
    chk("R4 boot on", 16'(boot_rom_on), 16'h1);
    chk("R3 vec kept", vec_base, 16'hBFFA);
    wr(RA, 8'b0111_0000);
    chk("R7 no set", 16'(mode_code), 16'h0);
    chk("R6 blocked", 16'(reg_rdata), 16'h90);
    wr(RA, 8'b0110_1111);
    chk("R8 irv locked", 16'(reg_rdata), 16'h9F);
    chk("R10 prio", 16'(prio_sel), 16'hF);
  endtask

  // Normal-mode write-once visibility.
  task automatic t_normal();
    do_reset(1'b1, 1'b1);
    wr(RA, 8'b1101_0011);
    chk("R6 rdata", 16'(reg_rdata), 16'h33);
    chk("R9 vis exp", 16'(show_reads), 16'h1);
    wr(RA, 8'b0000_0000);
    chk("R8 second", 16'(reg_rdata), 16'h30);
    chk("R9 vis kept", 16'(show_reads), 16'h1);
    do_reset(1'b0, 1'b1);
    wr(RA, 8'b0001_0100);
    chk("R8 first", 16'(reg_rdata), 16'h14);
    chk("R9 single gated", 16'(show_reads), 16'h0);
  endtask

  // Address decode.
  task automatic t_addr();
    do_reset(1'b1, 1'b0);
    wr(6'h3B, 8'h00);
    chk("R11 miss mode", 16'(mode_code), 16'h3);
    chk("R11 miss prio", 16'(prio_sel), 16'h6);
    reg_addr = 6'h00;
    #1;
    chk("R11 rdata zero", 16'(reg_rdata), 16'h0);
    reg_addr = RA;
    #1;
    chk("R11 rdata hit", 16'(reg_rdata), 16'h66);
  endtask

  initial begin
    fork
      begin
        t_reset_modes();
        t_special();
        t_normal();
        t_addr();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule